// File: doc/BRIEF.md
# Software Write-Lock Command Sequencer

This block sits between the write-strobe capture logic of a byte-wide non-volatile memory and its page buffer. Each write cycle reaches it as a one-cycle strobe carrying the captured 17-bit address and 8-bit data. The block looks for fixed address/data key patterns. A three-cycle key followed by any write turns a persistent write-lock on. A six-cycle key turns it off. While the lock is on, an ordinary write gets through only if the three-cycle key comes directly before it.

For every strobe the block makes one registered decision, in the cycle after the strobe. The write is passed to the page buffer with its address and data, it is blocked, or it is consumed as a key cycle and produces neither. An external hardware-inhibit input, active low, blocks every write while it is low. It also sends the key matcher back to its idle point. It leaves the lock flag as it is.

Top module: `wlock_seq`

## Requirements
- R1: After the power-up reset `rstN`, `protOn` is 0 and neither `wrPass` nor `wrBlock` is asserted.
- R2: With the lock off and no key in progress, a strobed write that is not a first key cycle asserts `wrPass`. In that same cycle `passAddr` and `passData` hold the strobed address and data.
- R3: The key cycles are data 0xAA at address 0x5555, then data 0x55 at 0x2AAA, then a command byte at 0x5555. Only address bits [14:0] take part in the comparison. Each recognised key cycle is consumed: it asserts neither `wrPass` nor `wrBlock`.
- R4: The key followed by command 0xA0 arms the block. The next strobe, whatever its address and data, sets `protOn` to 1 and is passed on.
- R5: With the lock on, a write that does not directly follow the armed key is blocked. A write that completes an armed key is passed, and `protOn` stays 1.
- R6: The six-cycle key clears `protOn` to 0 on its last cycle. Its cycles are 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x20@0x5555. None of these cycles is passed or blocked.
- R7: A cycle that breaks a partly received key sends the matcher back to idle. The same cycle is then judged again as a possible first key cycle or as an ordinary write.
- R8: While `resPin` is 0, every strobe asserts `wrBlock`, the matcher returns to idle, and `protOn` keeps its value.
- R9: The decision for a strobe at clock edge k is visible after edge k+1, for exactly one cycle. `wrPass` and `wrBlock` are never high together, and neither is high without a strobe.
- R10: `protOn` changes only at a strobe that completes an arm (R4) or a clear (R6) key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-up reset, active low, synchronous |
| resPin | input | 1 | Hardware write inhibit, writes allowed when 1 |
| wrStb | input | 1 | One-cycle write strobe |
| wrAddr | input | 17 | Captured write address |
| wrData | input | 8 | Captured write data |
| protOn | output | 1 | Write-lock flag |
| wrPass | output | 1 | Write forwarded to page buffer (one cycle) |
| wrBlock | output | 1 | Write refused (one cycle) |
| passAddr | output | 17 | Address of the forwarded write |
| passData | output | 8 | Data of the forwarded write |

## Verification
The assertions check on every cycle that pass and block never coincide and that no decision appears without a strobe. They also check that an inhibited strobe is blocked and that the lock flag holds between strobes and while inhibited. Finally, they check that a rise of the lock is always paired with a passed write and a fall with a consumed cycle. Several behaviours can only be shown by the bench's scenarios. These are which exact byte patterns count as keys and that the upper address bit is ignored. They also include the re-judging of a breaking cycle, the re-arming needed for each write under lock, and the need to restart a key interrupted by the inhibit.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_ARMED,
    S_ER3,
    S_ER4,
    S_ER5
  } seqState_t;

  typedef struct packed {
    logic keyA;
    logic keyB;
    logic cmdLock;
    logic cmdErase;
    logic cmdClear;
  } keyHits_t;

  typedef struct packed {
    logic pass;
    logic block;
    logic setProt;
    logic clrProt;
  } ctrlStb_t;

endpackage

// File: rtl/wlock_dp.sv
module wlock_dp
  import wlock_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int KEY_AW = 15,
  parameter logic [KEY_AW-1:0] ADDR_A = 15'h5555,
  parameter logic [KEY_AW-1:0] ADDR_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] DATA_A = 8'hAA,
  parameter logic [DATA_W-1:0] DATA_B = 8'h55,
  parameter logic [DATA_W-1:0] CMD_LOCK = 8'hA0,
  parameter logic [DATA_W-1:0] CMD_ERASE = 8'h80,
  parameter logic [DATA_W-1:0] CMD_CLEAR = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStb_t          stb,
  output keyHits_t          hits,
  output logic              protOn,
  output logic              wrPass,
  output logic              wrBlock,
  output logic [ADDR_W-1:0] passAddr,
  output logic [DATA_W-1:0] passData
);

  logic [KEY_AW-1:0] lowAddr;
  logic atA;
  logic atB;

  assign lowAddr = wrAddr[KEY_AW-1:0];
  assign atA = (lowAddr == ADDR_A);
  assign atB = (lowAddr == ADDR_B);

  always_comb begin
    hits.keyA     = atA && (wrData == DATA_A);
    hits.keyB     = atB && (wrData == DATA_B);
    hits.cmdLock  = atA && (wrData == CMD_LOCK);
    hits.cmdErase = atA && (wrData == CMD_ERASE);
    hits.cmdClear = atA && (wrData == CMD_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protOn   <= 1'b0;
      wrPass   <= 1'b0;
      wrBlock  <= 1'b0;
      passAddr <= '0;
      passData <= '0;
    end else begin
      if (stb.setProt) protOn <= 1'b1;
      else if (stb.clrProt) protOn <= 1'b0;
      wrPass  <= stb.pass;
      wrBlock <= stb.block;
      if (stb.pass) begin
        passAddr <= wrAddr;
        passData <= wrData;
      end
    end
  end

endmodule

// File: rtl/wlock_ctrl.sv
module wlock_ctrl
  import wlock_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     resPin,
  input  logic     wrStb,
  input  keyHits_t hits,
  input  logic     protOn,
  output ctrlStb_t stb
);

  seqState_t state;
  seqState_t nxt;
  logic restart;

  always_comb begin
    nxt     = state;
    stb     = '0;
    restart = 1'b0;
    if (wrStb) begin
      if (!resPin) begin
        stb.block = 1'b1;
        nxt       = S_IDLE;
      end else begin
        restart = 1'b1;
        case (state)
          S_KEY1: if (hits.keyB) begin nxt = S_KEY2; restart = 1'b0; end
          S_KEY2: begin
            if (hits.cmdLock) begin nxt = S_ARMED; restart = 1'b0; end
            else if (hits.cmdErase) begin nxt = S_ER3; restart = 1'b0; end
          end
          S_ARMED: begin
            stb.setProt = 1'b1;
            stb.pass    = 1'b1;
            nxt         = S_IDLE;
            restart     = 1'b0;
          end
          S_ER3: if (hits.keyA) begin nxt = S_ER4; restart = 1'b0; end
          S_ER4: if (hits.keyB) begin nxt = S_ER5; restart = 1'b0; end
          S_ER5: if (hits.cmdClear) begin
            stb.clrProt = 1'b1;
            nxt         = S_IDLE;
            restart     = 1'b0;
          end
          default: ;
        endcase
        if (restart) begin
          if (hits.keyA) begin
            nxt = S_KEY1;
          end else begin
            nxt = S_IDLE;
            if (protOn) stb.block = 1'b1;
            else stb.pass = 1'b1;
          end
        end
      end
    end else if (!resPin) begin
      nxt = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else state <= nxt;
  end

endmodule

// File: rtl/wlock_seq.sv
module wlock_seq
  import wlock_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int KEY_AW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resPin,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              protOn,
  output logic              wrPass,
  output logic              wrBlock,
  output logic [ADDR_W-1:0] passAddr,
  output logic [DATA_W-1:0] passData
);

  keyHits_t hits;
  ctrlStb_t stb;

  wlock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .resPin(resPin), .wrStb(wrStb),
    .hits(hits), .protOn(protOn), .stb(stb)
  );

  wlock_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_AW(KEY_AW)) u_dp (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData), .stb(stb),
    .hits(hits), .protOn(protOn), .wrPass(wrPass), .wrBlock(wrBlock),
    .passAddr(passAddr), .passData(passData)
  );

endmodule

// File: rtl/wlock_seq_chk.sv
module wlock_seq_chk (
  input logic clk,
  input logic rstN,
  input logic resPin,
  input logic wrStb,
  input logic protOn,
  input logic wrPass,
  input logic wrBlock
);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrPass |-> !wrBlock);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb |=> (!wrPass && !wrBlock));

  p_inhibit_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !resPin) |=> wrBlock);

  p_inhibit_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    !resPin |=> $stable(protOn));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb |=> $stable(protOn));

  p_lock_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protOn) |-> wrPass);

  p_clear_eat_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protOn) |-> (!wrPass && !wrBlock));

endmodule

bind wlock_seq wlock_seq_chk u_chk (.*);

// File: tb/wlock_seq_bench.sv
`timescale 1ns/1ps
module wlock_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resPin = 1'b1;
  logic        wrStb = 1'b0;
  logic [16:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        protOn, wrPass, wrBlock;
  logic [16:0] passAddr;
  logic [7:0]  passData;

  always #2 clk = ~clk;

  wlock_seq u_wlock_seq (
    .clk(clk), .rstN(rstN), .resPin(resPin), .wrStb(wrStb),
    .wrAddr(wrAddr), .wrData(wrData), .protOn(protOn), .wrPass(wrPass),
    .wrBlock(wrBlock), .passAddr(passAddr), .passData(passData)
  );

  typedef struct {
    logic        pass;
    logic        block;
    logic [16:0] addr;
    logic [7:0]  data;
    logic        prot;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   nCmp = 0;
  int   nBad = 0;
  int   mSt = 0;
  logic mProt = 1'b0;
  bit   done = 1'b0;
  bit   live = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model of the key rules, written from the requirements
  task automatic model(input logic [16:0] a, input logic [7:0] d, output exp_t e);
    logic ka, kb, at5;
    logic again;
    at5 = (a[14:0] == 15'h5555);
    ka  = at5 && d == 8'hAA;
    kb  = (a[14:0] == 15'h2AAA) && d == 8'h55;
    e.pass = 0; e.block = 0; e.addr = a; e.data = d;
    again = 1;
    if (!resPin) begin
      e.block = 1; mSt = 0; again = 0;
    end else begin
      case (mSt)
        1: if (kb) begin mSt = 2; again = 0; end
        2: if (at5 && d == 8'hA0) begin mSt = 3; again = 0; end
           else if (at5 && d == 8'h80) begin mSt = 4; again = 0; end
        3: begin mProt = 1; mSt = 0; e.pass = 1; again = 0; end
        4: if (ka) begin mSt = 5; again = 0; end
        5: if (kb) begin mSt = 6; again = 0; end
        6: if (at5 && d == 8'h20) begin mProt = 0; mSt = 0; again = 0; end
        default: ;
      endcase
      if (again) begin
        if (ka) mSt = 1;
        else begin
          mSt = 0;
          if (mProt) e.block = 1; else e.pass = 1;
        end
      end
    end
    e.prot = mProt;
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    model(a, d, e);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic setRes(input logic v);
    @(negedge clk);
    resPin = v;
    if (!v) mSt = 0;
  endtask

  task automatic keyLock(string tag);
    wr(17'h05555, 8'hAA, tag);
    wr(17'h02AAA, 8'h55, tag);
    wr(17'h05555, 8'hA0, tag);
  endtask

  task automatic keyClear(string tag);
    wr(17'h05555, 8'hAA, tag);
    wr(17'h02AAA, 8'h55, tag);
    wr(17'h05555, 8'h80, tag);
    wr(17'h05555, 8'hAA, tag);
    wr(17'h02AAA, 8'h55, tag);
    wr(17'h05555, 8'h20, tag);
  endtask

  // Monitor: pops one expected item per strobe, checks the cycle after
  always @(posedge clk) begin
    logic hit;
    exp_t e;
    hit = wrStb;
    #1;
    if (live) begin
      if (hit) begin
        if (q.size() == 0) begin
          check("R9", "missing expectation", 1, 0);
        end else begin
          e = q.pop_front();
          check(e.tag, "wrPass", wrPass, e.pass);
          check(e.tag, "wrBlock", wrBlock, e.block);
          check({e.tag, "/R10"}, "protOn", protOn, e.prot);
          if (e.pass) begin
            check(e.tag, "passAddr", passAddr, e.addr);
            check(e.tag, "passData", passData, e.data);
          end
        end
      end else begin
        check("R9", "idle decision", {wrPass, wrBlock}, 0);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "protOn", protOn, 0);
    check("R1", "wrPass", wrPass, 0);
    check("R1", "wrBlock", wrBlock, 0);
    live = 1'b1;

    wr(17'h00123, 8'h3C, "R2");
    wr(17'h1ABCD, 8'hF0, "R2");

    // keys with address bit 16 set still match; bad command breaks
    wr(17'h15555, 8'hAA, "R3");
    wr(17'h12AAA, 8'h55, "R3");
    wr(17'h05555, 8'h20, "R7");

    // repeated first key, then an ordinary byte breaks the key
    wr(17'h05555, 8'hAA, "R7");
    wr(17'h05555, 8'hAA, "R7");
    wr(17'h00777, 8'h11, "R7");

    keyLock("R4");
    wr(17'h10042, 8'h99, "R4");

    wr(17'h00042, 8'h77, "R5");
    keyLock("R5");
    wr(17'h00043, 8'h66, "R5");
    wr(17'h00044, 8'h55, "R5");

    // inhibit: strobes blocked, key in progress forgotten, lock kept
    setRes(1'b0);
    wr(17'h05555, 8'hAA, "R8");
    setRes(1'b1);
    wr(17'h02AAA, 8'h55, "R8");
    wr(17'h05555, 8'hAA, "R8");
    wr(17'h02AAA, 8'h55, "R8");
    setRes(1'b0);
    wr(17'h05555, 8'hA0, "R8");
    setRes(1'b1);
    wr(17'h00050, 8'h01, "R8");

    // broken clear key leaves lock on
    wr(17'h05555, 8'hAA, "R7");
    wr(17'h02AAA, 8'h55, "R7");
    wr(17'h05555, 8'h80, "R7");
    wr(17'h05555, 8'hAA, "R7");
    wr(17'h02AAA, 8'h55, "R7");
    wr(17'h02AAA, 8'h55, "R7");
    wr(17'h00060, 8'h5A, "R7");

    keyClear("R6");
    wr(17'h00061, 8'hC3, "R6");
    keyClear("R6");
    wr(17'h1FFFF, 8'h00, "R2");

    repeat (3) @(negedge clk);
    check("R9", "queue drained", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule